// File: doc/BRIEF.md
# Byte-Level Serial NOR Flash Command Engine

This block is the slave side of a serial NOR flash, seen one whole byte at a time. While chip select is low, every byte the host sends produces exactly one response byte. The first byte of a transaction is an opcode. Depending on the opcode, the engine then does one of three things:

- collects address, dummy or argument bytes,
- streams array contents or writes incoming bytes into an on-chip byte array,
- plays back bytes from a small response buffer.

The response buffer serves identification, status and extended-address reads.

The array is a power-of-two RAM. After reset it is swept to 0xFF. Erase commands fill a sector or the whole array with 0xFF, one byte per clock. Input is refused while a fill runs.

Both the byte to the engine and the byte back to the host travel on valid/ready handshakes.

- A byte moves on `in_valid && in_ready`.
- A response byte moves on `out_valid && out_ready`.
- `in_ready` is low while chip select is high, while a fill is running, and while an earlier response waits on a low `out_ready`.
- A waiting response keeps its value until it is taken.

Top module: `spi_flash_engine`

## Requirements
- R1: After reset the engine sweeps the whole array to 0xFF while holding `in_ready` low, `out_valid` is low, and every later read of an unwritten location returns 0xFF.
- R2: Each accepted byte yields exactly one response byte. While `out_valid` is high and `out_ready` is low, `out_byte` holds and `in_ready` is low. `in_ready` is low whenever `cs_n` is high.
- R3: Opcode 0x03 followed by three address bytes, most significant first, starts a read. The responses to the opcode and address bytes are 0x00. Each later byte returns the array byte at the current address. The address then steps by one and wraps modulo the array size.
- R4: Opcode 0x0B takes the address, then DUMMY_BYTES dummy bytes that answer 0x00, and then returns data as in R3.
- R5: Opcode 0x02 followed by an address programs the array. Each following byte is ANDed into the array byte at the current address, which steps by one and wraps modulo the array size.
- R6: Opcode 0xB7 selects four-byte addressing and 0xE9 returns to three-byte addressing. Opcode 0x05 returns a status byte, repeated until chip select rises: bit 0 is the four-byte mode flag and the other bits are zero.
- R7: Opcode 0xC5 with one argument byte loads the extended-address register. Opcode 0xC8 returns that register once, after which the next byte is decoded as a new opcode. In three-byte mode the address is {register, a0, a1, a2} masked with (array size − 1).
- R8: Opcode 0x9F returns the ID_LEN identification bytes, most significant first, then zero bytes up to RESP_DEPTH bytes in total. After that the next byte is decoded as a new opcode.
- R9: Any other opcode makes every following byte return 0x00 until chip select rises.
- R10: Raising `cs_n` abandons the transaction in progress. A partly sent address has no effect, and the next byte after chip select falls is decoded as an opcode.
- R11: Opcode 0x20 with an address fills the SECTOR_BYTES-aligned sector holding that address with 0xFF, and 0xC7 fills the whole array. Neither touches other bytes, and `in_ready` is low from the cycle after the command completes until the fill ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select; high ends the transaction |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Engine accepts the offered byte this cycle |
| in_byte | input | 8 | Byte from the host |
| out_valid | output | 1 | Response byte available |
| out_ready | input | 1 | Host takes the response byte this cycle |
| out_byte | output | 8 | Response byte |

## Verification
The main function is driven with four kinds of traffic, each chosen to expose a different fault:

- **Plain and fast reads at several addresses, including one that crosses the top of the array.** These separate correct address assembly and wrap from off-by-one or missing dummy handling.
- **Programming the same byte twice with overlapping bit patterns.** This shows that bits are only ever cleared rather than overwritten.
- **Buffered replies: identification, status, extended-address read and an unknown opcode.** These tell a looping playback from a single pass followed by a fresh decode.
- **Transactions cut short by chip select, and a sector erase next to untouched data.** These show that abandoned arguments leave nothing behind and that the fill stays inside its sector.

// File: rtl/spif_pkg.sv
package spif_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_PROG,
    ST_READ,
    ST_PLAY
  } spif_state_e;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SECT = 8'h20;
  localparam logic [7:0] OP_CHIP = 8'hC7;
  localparam logic [7:0] OP_ID   = 8'h9F;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [7:0] OP_EN4  = 8'hB7;
  localparam logic [7:0] OP_EX4  = 8'hE9;
  localparam logic [7:0] OP_WEXT = 8'hC5;
  localparam logic [7:0] OP_REXT = 8'hC8;

endpackage

// File: rtl/spif_array.sv
module spif_array #(
  parameter int MEM_BYTES = 1024,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          prog_en,
  input  logic [AW-1:0] prog_addr,
  input  logic [7:0]    prog_data,
  input  logic          fill_start,
  input  logic [AW-1:0] fill_base,
  input  logic [AW:0]   fill_len,
  output logic          busy
);

  localparam logic [AW:0] FULL_LEN = (AW+1)'(MEM_BYTES);

  logic [7:0]    mem [MEM_BYTES];
  logic [AW-1:0] fill_ptr_q;
  logic [AW:0]   fill_left_q;

  assign busy    = (fill_left_q != '0);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_ptr_q  <= '0;
      fill_left_q <= FULL_LEN;
    end else if (busy) begin
      fill_ptr_q  <= fill_ptr_q + AW'(1);
      fill_left_q <= fill_left_q - (AW+1)'(1);
    end else if (fill_start) begin
      fill_ptr_q  <= fill_base;
      fill_left_q <= fill_len;
    end
  end

  always_ff @(posedge clk) begin
    if (busy) begin
      mem[fill_ptr_q] <= 8'hFF;
    end else if (prog_en) begin
      mem[prog_addr] <= mem[prog_addr] & prog_data;
    end
  end

  // R11: a new fill is only requested once the previous one has finished
  a_r11_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |-> !busy);

  // R11: programming never overlaps a running fill
  a_r11_no_prog_during_fill: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !prog_en);

  // R1: a running fill counts down by exactly one each cycle
  a_r1_fill_progress: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (fill_left_q == $past(fill_left_q) - (AW+1)'(1)));

endmodule

// File: rtl/spif_argbuf.sv
module spif_argbuf #(
  parameter int ARG_BYTES = 8,
  localparam int CW = $clog2(ARG_BYTES + 1),
  localparam int HEAD = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 start,
  input  logic [CW-1:0]        need,
  input  logic                 push,
  input  logic [7:0]           push_byte,
  output logic                 done,
  output logic                 overflow,
  output logic [HEAD-1:0][7:0] head
);

  logic [ARG_BYTES-1:0][7:0] buf_q;
  logic [ARG_BYTES-1:0][7:0] view;
  logic [CW-1:0]             cnt_q;
  logic [CW-1:0]             need_q;

  assign overflow = push && (cnt_q >= CW'(ARG_BYTES));
  assign done     = push && !overflow && (cnt_q + CW'(1) == need_q);

  // Buffer contents as they will be once the byte on the input is stored.
  always_comb begin
    view = buf_q;
    for (int i = 0; i < ARG_BYTES; i++) begin
      if (push && cnt_q == CW'(i)) view[i] = push_byte;
    end
  end

  for (genvar g = 0; g < HEAD; g++) begin : g_head
    assign head[g] = view[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      need_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q  <= '0;
      need_q <= need;
    end else if (push) begin
      if (done || overflow) begin
        cnt_q <= '0;
      end else begin
        buf_q <= view;
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R3: the collected byte count never reaches the count asked for
  a_r3_arg_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) || (cnt_q < need_q));

  // R10: a cleared collector starts over from the first byte
  a_r10_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/spif_respbuf.sv
module spif_respbuf #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  load,
  input  logic [DEPTH-1:0][7:0] load_data,
  input  logic [LW-1:0]         load_len,
  input  logic                  load_loop,
  input  logic                  pop,
  output logic [7:0]            cur_byte,
  output logic                  last,
  output logic                  looping
);

  logic [DEPTH-1:0][7:0] data_q;
  logic [PW-1:0]         pos_q;
  logic [LW-1:0]         len_q;
  logic                  loop_q;

  assign cur_byte = data_q[pos_q];
  assign last     = (LW'(pos_q) == len_q - LW'(1));
  assign looping  = loop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      pos_q  <= '0;
      len_q  <= '0;
      loop_q <= 1'b0;
    end else if (clear) begin
      pos_q  <= '0;
      len_q  <= '0;
      loop_q <= 1'b0;
    end else if (load) begin
      data_q <= load_data;
      pos_q  <= '0;
      len_q  <= load_len;
      loop_q <= load_loop;
    end else if (pop) begin
      pos_q <= last ? '0 : pos_q + PW'(1);
    end
  end

  // R8: the playback position stays inside the loaded length
  a_r8_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) |-> (LW'(pos_q) < len_q));

  // R10: chip select release empties the buffer and drops the repeat flag
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> ((len_q == '0) && !loop_q));

endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine
  import spif_pkg::*;
#(
  parameter int MEM_BYTES    = 1024,
  parameter int SECTOR_BYTES = 256,
  parameter int DUMMY_BYTES  = 1,
  parameter int ARG_BYTES    = 8,
  parameter int ID_LEN       = 3,
  parameter logic [8*ID_LEN-1:0] ID_VALUE = 24'h5AA713,
  parameter int RESP_DEPTH   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int SW = $clog2(SECTOR_BYTES);
  localparam int CW = $clog2(ARG_BYTES + 1);
  localparam int LW = $clog2(RESP_DEPTH + 1);
  localparam logic [AW:0] FULL_LEN = (AW+1)'(MEM_BYTES);
  localparam logic [AW:0] SECT_LEN = (AW+1)'(SECTOR_BYTES);

  spif_state_e state_q, nxt_state;
  logic [7:0]    cmd_q;
  logic          addr4_q;
  logic [7:0]    ear_q;
  logic [AW-1:0] cur_q;
  logic          out_valid_q;
  logic [7:0]    out_byte_q;

  logic          accept;
  logic          fill_busy;
  logic [7:0]    arr_rd;
  logic [CW-1:0] alen;
  logic [AW-1:0] addr_asm;
  logic [7:0]    rsp;

  logic          arg_start, arg_push, arg_done, arg_over;
  logic [CW-1:0] arg_need;
  logic [3:0][7:0] arg_head;

  logic                       resp_load, resp_loop, resp_last, resp_looping, resp_pop;
  logic [RESP_DEPTH-1:0][7:0] resp_data;
  logic [RESP_DEPTH-1:0][7:0] id_bytes;
  logic [LW-1:0]              resp_len;
  logic [7:0]                 resp_cur;

  logic          fill_start;
  logic [AW-1:0] fill_base;
  logic [AW:0]   fill_len;
  logic          set4, clr4, ear_we, cur_load, prog_en;

  assign in_ready  = !cs_n && !fill_busy && (!out_valid_q || out_ready);
  assign accept    = in_valid && in_ready;
  assign out_valid = out_valid_q;
  assign out_byte  = out_byte_q;

  assign alen = addr4_q ? CW'(4) : CW'(3);
  assign addr_asm = addr4_q
    ? AW'({arg_head[0], arg_head[1], arg_head[2], arg_head[3]})
    : AW'({ear_q, arg_head[0], arg_head[1], arg_head[2]});

  for (genvar g = 0; g < RESP_DEPTH; g++) begin : g_id
    if (g < ID_LEN) begin : g_val
      assign id_bytes[g] = ID_VALUE[8*(ID_LEN-1-g) +: 8];
    end else begin : g_pad
      assign id_bytes[g] = 8'h00;
    end
  end

  spif_array #(.MEM_BYTES(MEM_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(cur_q), .rd_data(arr_rd),
    .prog_en(prog_en), .prog_addr(cur_q), .prog_data(in_byte),
    .fill_start(fill_start), .fill_base(fill_base), .fill_len(fill_len),
    .busy(fill_busy)
  );

  assign arg_push = accept && (state_q == ST_COLLECT);

  spif_argbuf #(.ARG_BYTES(ARG_BYTES)) u_args (
    .clk(clk), .rst_n(rst_n), .clear(cs_n),
    .start(arg_start), .need(arg_need),
    .push(arg_push), .push_byte(in_byte),
    .done(arg_done), .overflow(arg_over), .head(arg_head)
  );

  assign resp_pop = accept && (state_q == ST_PLAY);

  spif_respbuf #(.DEPTH(RESP_DEPTH)) u_resp (
    .clk(clk), .rst_n(rst_n), .clear(cs_n),
    .load(resp_load), .load_data(resp_data), .load_len(resp_len),
    .load_loop(resp_loop), .pop(resp_pop),
    .cur_byte(resp_cur), .last(resp_last), .looping(resp_looping)
  );

  // Command decode and per-state byte handling
  always_comb begin
    nxt_state  = state_q;
    arg_start  = 1'b0;
    arg_need   = alen;
    resp_load  = 1'b0;
    resp_data  = '0;
    resp_len   = LW'(1);
    resp_loop  = 1'b0;
    fill_start = 1'b0;
    fill_base  = '0;
    fill_len   = FULL_LEN;
    set4       = 1'b0;
    clr4       = 1'b0;
    ear_we     = 1'b0;
    cur_load   = 1'b0;
    prog_en    = 1'b0;
    if (accept) begin
      unique case (state_q)
        ST_IDLE: begin
          unique case (in_byte)
            OP_READ, OP_PROG, OP_SECT: begin
              arg_start = 1'b1;
              nxt_state = ST_COLLECT;
            end
            OP_FAST: begin
              arg_start = 1'b1;
              arg_need  = alen + CW'(DUMMY_BYTES);
              nxt_state = ST_COLLECT;
            end
            OP_WEXT: begin
              arg_start = 1'b1;
              arg_need  = CW'(1);
              nxt_state = ST_COLLECT;
            end
            OP_CHIP: fill_start = 1'b1;
            OP_EN4:  set4 = 1'b1;
            OP_EX4:  clr4 = 1'b1;
            OP_ID: begin
              resp_load = 1'b1;
              resp_data = id_bytes;
              resp_len  = LW'(RESP_DEPTH);
              nxt_state = ST_PLAY;
            end
            OP_STAT: begin
              resp_load    = 1'b1;
              resp_data[0] = {7'b0, addr4_q};
              resp_loop    = 1'b1;
              nxt_state    = ST_PLAY;
            end
            OP_REXT: begin
              resp_load    = 1'b1;
              resp_data[0] = ear_q;
              nxt_state    = ST_PLAY;
            end
            default: begin
              resp_load = 1'b1;
              resp_loop = 1'b1;
              nxt_state = ST_PLAY;
            end
          endcase
        end
        ST_COLLECT: begin
          if (arg_over) begin
            nxt_state = ST_IDLE;
          end else if (arg_done) begin
            nxt_state = ST_IDLE;
            unique case (cmd_q)
              OP_READ, OP_FAST: begin
                cur_load  = 1'b1;
                nxt_state = ST_READ;
              end
              OP_PROG: begin
                cur_load  = 1'b1;
                nxt_state = ST_PROG;
              end
              OP_SECT: begin
                fill_start = 1'b1;
                fill_base  = {addr_asm[AW-1:SW], {SW{1'b0}}};
                fill_len   = SECT_LEN;
              end
              OP_WEXT: ear_we = 1'b1;
              default: ;
            endcase
          end
        end
        ST_PROG: prog_en = 1'b1;
        ST_PLAY: begin
          if (resp_last && !resp_looping) nxt_state = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_READ: rsp = arr_rd;
      ST_PLAY: rsp = resp_cur;
      default: rsp = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= 8'h00;
      addr4_q <= 1'b0;
      ear_q   <= 8'h00;
      cur_q   <= '0;
    end else if (cs_n) begin
      state_q <= ST_IDLE;
    end else if (accept) begin
      state_q <= nxt_state;
      if (state_q == ST_IDLE) cmd_q <= in_byte;
      if (set4) addr4_q <= 1'b1;
      if (clr4) addr4_q <= 1'b0;
      if (ear_we) ear_q <= arg_head[0];
      if (cur_load) begin
        cur_q <= addr_asm;
      end else if (state_q == ST_READ || state_q == ST_PROG) begin
        cur_q <= cur_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_byte_q  <= 8'h00;
    end else if (accept) begin
      out_valid_q <= 1'b1;
      out_byte_q  <= rsp;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  // R2: a response not yet taken stays put
  a_r2_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && !out_ready) |=> (out_valid_q && $stable(out_byte_q)));

  // R2: nothing is taken while chip select is high
  a_r2_no_accept_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !accept);

  // R10: chip select release returns to idle
  a_r10_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (state_q == ST_IDLE));

  // R3: the read address steps by one per data byte
  a_r3_read_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && accept) |=> (cur_q == $past(cur_q) + AW'(1)));

  // R5: the program address steps by one per data byte
  a_r5_prog_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG && accept) |=> (cur_q == $past(cur_q) + AW'(1)));

endmodule

// File: tb/sim_spi_flash_engine.sv
`timescale 1ns/1ps
module sim_spi_flash_engine;

  localparam int MEM  = 1024;
  localparam int SECT = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_byte;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  spi_flash_engine u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
  );

  // Behavioural reference model, stepped once per transferred byte
  logic [7:0] mem_m [MEM];
  int         m_state;   // 0 idle, 1 collect, 2 program, 3 read, 4 playback
  logic [7:0] m_cmd;
  bit         m_a4;
  logic [7:0] m_ear;
  int         m_cur;
  int         m_need;
  logic [7:0] m_args[$];
  logic [7:0] m_resp[$];
  int         m_pos;
  bit         m_loop;

  function automatic void m_reset();
    for (int i = 0; i < MEM; i++) mem_m[i] = 8'hFF;
    m_state = 0; m_a4 = 0; m_ear = 0; m_cur = 0; m_need = 0;
    m_args.delete(); m_resp.delete(); m_pos = 0; m_loop = 0;
  endfunction

  function automatic void m_deselect();
    m_state = 0; m_args.delete(); m_resp.delete(); m_pos = 0; m_loop = 0;
  endfunction

  function automatic logic [7:0] m_xfer(input logic [7:0] tx);
    logic [7:0] r;
    int a;
    r = 8'h00;
    case (m_state)
      0: begin
        m_cmd = tx;
        case (tx)
          8'h03, 8'h02, 8'h20: begin m_need = m_a4 ? 4 : 3; m_args.delete(); m_state = 1; end
          8'h0B: begin m_need = (m_a4 ? 4 : 3) + 1; m_args.delete(); m_state = 1; end
          8'hC5: begin m_need = 1; m_args.delete(); m_state = 1; end
          8'hC7: for (int i = 0; i < MEM; i++) mem_m[i] = 8'hFF;
          8'hB7: m_a4 = 1;
          8'hE9: m_a4 = 0;
          8'h9F: begin m_resp = '{8'h5A, 8'hA7, 8'h13, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
                       m_loop = 0; m_pos = 0; m_state = 4; end
          8'h05: begin m_resp = '{{7'b0, m_a4}}; m_loop = 1; m_pos = 0; m_state = 4; end
          8'hC8: begin m_resp = '{m_ear}; m_loop = 0; m_pos = 0; m_state = 4; end
          default: begin m_resp = '{8'h00}; m_loop = 1; m_pos = 0; m_state = 4; end
        endcase
      end
      1: begin
        m_args.push_back(tx);
        if (m_args.size() == m_need) begin
          m_state = 0;
          if (m_a4) a = {m_args[0], m_args[1], m_args[2], m_args[3]};
          else a = {m_ear, m_args[0], m_args[1], m_args[2]};
          a = a & (MEM - 1);
          case (m_cmd)
            8'h03, 8'h0B: begin m_cur = a; m_state = 3; end
            8'h02: begin m_cur = a; m_state = 2; end
            8'h20: for (int i = 0; i < SECT; i++) mem_m[(a & ~(SECT - 1)) + i] = 8'hFF;
            8'hC5: m_ear = m_args[0];
            default: ;
          endcase
        end
      end
      2: begin mem_m[m_cur] = mem_m[m_cur] & tx; m_cur = (m_cur + 1) % MEM; end
      3: begin r = mem_m[m_cur]; m_cur = (m_cur + 1) % MEM; end
      default: begin
        r = m_resp[m_pos];
        m_pos++;
        if (m_pos == m_resp.size()) begin
          m_pos = 0;
          if (!m_loop) m_state = 0;
        end
      end
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!in_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input string req, output logic [7:0] got);
    logic [7:0] exp;
    wait_ready();
    exp = m_xfer(tx);
    in_valid = 1'b1;
    in_byte  = tx;
    @(negedge clk);
    in_valid = 1'b0;
    got = out_byte;
    chk({req, " response valid"}, {31'b0, out_valid}, 32'd1);
    chk(req, {24'b0, out_byte}, {24'b0, exp});
  endtask

  task automatic sel();
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic desel();
    @(negedge clk);
    cs_n = 1'b1;
    m_deselect();
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] tx, input string req);
    logic [7:0] g;
    xfer(tx, req, g);
  endtask

  task automatic rd_at(input int addr, input int n, input string req);
    sel();
    send(8'h03, req);
    send(addr[23:16], req);
    send(addr[15:8], req);
    send(addr[7:0], req);
    for (int i = 0; i < n; i++) send(8'h00, req);
    desel();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_err++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R2: idle outputs after reset and while deselected
    chk("R1 out_valid after reset", {31'b0, out_valid}, 32'd0);
    chk("R2 in_ready low while deselected", {31'b0, in_ready}, 32'd0);
    cs_n = 1'b0;
    @(negedge clk);
    chk("R1 in_ready low during initial sweep", {31'b0, in_ready}, 32'd0);
    cs_n = 1'b1;
    @(negedge clk);
    rd_at(32'h000100, 4, "R1 erased after reset");

    // R5 / R3: program, read back, then clear more bits
    sel();
    send(8'h02, "R5"); send(8'h00, "R5"); send(8'h01, "R5"); send(8'h00, "R5");
    send(8'h11, "R5"); send(8'h22, "R5"); send(8'hF0, "R5");
    desel();
    rd_at(32'h000100, 4, "R3 read after program");
    sel();
    send(8'h02, "R5"); send(8'h00, "R5"); send(8'h01, "R5"); send(8'h02, "R5");
    send(8'h3C, "R5");
    desel();
    sel();
    send(8'h03, "R3"); send(8'h00, "R3"); send(8'h01, "R3"); send(8'h02, "R3");
    xfer(8'h00, "R5 AND program", g);
    chk("R5 bits only cleared", {24'b0, g}, 32'h30);
    desel();

    // R5 / R3: program and read across the top of the array
    sel();
    send(8'h02, "R5"); send(8'h00, "R5"); send(8'h03, "R5"); send(8'hFE, "R5");
    send(8'hA1, "R5"); send(8'hB2, "R5"); send(8'hC3, "R5 wrap");
    desel();
    rd_at(32'h0003FE, 4, "R3 wrap read");
    rd_at(32'h000000, 1, "R5 wrapped byte at zero");

    // R4: fast read with one dummy byte
    sel();
    send(8'h0B, "R4"); send(8'h00, "R4"); send(8'h01, "R4"); send(8'h00, "R4");
    send(8'hDD, "R4 dummy");
    xfer(8'h00, "R4 data", g);
    chk("R4 first data byte", {24'b0, g}, 32'h11);
    send(8'h00, "R4"); send(8'h00, "R4");
    desel();

    // R2: back-pressure holds the response and blocks input
    sel();
    out_ready = 1'b0;
    xfer(8'h05, "R2 status opcode", g);
    for (int i = 0; i < 3; i++) begin
      chk("R2 held valid", {31'b0, out_valid}, 32'd1);
      chk("R2 held byte", {24'b0, out_byte}, {24'b0, g});
      chk("R2 in_ready low under back-pressure", {31'b0, in_ready}, 32'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    send(8'h00, "R2 after release");
    desel();

    // R6: four-byte addressing and status
    sel(); send(8'hB7, "R6 enter"); desel();
    sel();
    send(8'h05, "R6");
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, "R6 status repeat", g);
      chk("R6 status flag", {24'b0, g}, 32'h01);
    end
    desel();
    sel();
    send(8'h03, "R6"); send(8'h00, "R6"); send(8'h00, "R6"); send(8'h01, "R6"); send(8'h01, "R6");
    xfer(8'h00, "R6 four-byte read", g);
    chk("R6 four-byte address data", {24'b0, g}, 32'h22);
    desel();
    sel(); send(8'hE9, "R6 exit"); desel();
    sel(); send(8'h05, "R6"); send(8'h00, "R6 status cleared"); desel();

    // R7: extended address register
    sel(); send(8'hC5, "R7"); send(8'h07, "R7"); desel();
    sel();
    send(8'hC8, "R7");
    xfer(8'h00, "R7 ext readback", g);
    chk("R7 ext value", {24'b0, g}, 32'h07);
    send(8'h05, "R7 next opcode decoded");
    send(8'h00, "R7 status after ext read");
    desel();
    rd_at(32'h000100, 1, "R7 masked three-byte address");

    // R8: identification
    sel();
    send(8'h9F, "R8");
    for (int i = 0; i < 8; i++) send(8'h00, "R8 id byte");
    send(8'h05, "R8 decode after id");
    send(8'h00, "R8 status after id");
    desel();

    // R9: unknown opcode
    sel();
    send(8'h77, "R9");
    for (int i = 0; i < 4; i++) send(8'hFF, "R9 zero fill");
    desel();

    // R10: partial address abandoned by deselect
    sel(); send(8'h02, "R10"); send(8'h00, "R10"); desel();
    sel(); send(8'h05, "R10 fresh decode"); send(8'h00, "R10 status"); desel();
    rd_at(32'h000100, 2, "R10 array untouched");

    // R11: sector erase then chip erase
    sel();
    send(8'h20, "R11"); send(8'h00, "R11"); send(8'h01, "R11"); send(8'h10, "R11");
    chk("R11 in_ready low during sector fill", {31'b0, in_ready}, 32'd0);
    desel();
    rd_at(32'h000100, 3, "R11 sector erased");
    rd_at(32'h0003FE, 2, "R11 other sector kept");
    sel();
    send(8'hC7, "R11");
    chk("R11 in_ready low during chip fill", {31'b0, in_ready}, 32'd0);
    desel();
    rd_at(32'h0003FE, 2, "R11 chip erased");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule